// File: doc/BRIEF.md
# Two-Wire Bus Master Transaction Engine

This block is the master side of a two-wire serial bus. A single command runs one complete transaction. The engine first signals a START. It then shifts out a 7-bit target address followed by a direction bit. Next it either sends a number of bytes or receives them, and it closes with a STOP. After each byte the engine checks the target's acknowledge when it is sending, and it returns its own acknowledge when it is receiving.

The host places the address, the direction and a byte count on the inputs and pulses `go`. For a write, the engine loads a byte from `wr_data` each time it needs one and pulses `wr_take` in that same cycle. The host then presents the next byte. For a read, each received byte appears on `rd_data` together with a one-cycle `rd_valid`. A one-cycle `done` marks the end of the transaction. `err` reports whether the target failed to acknowledge. The bus pins are open-drain: an output enable of 1 pulls the line low. The SDA line is sampled back through `sda_in`. Each bit lasts four quarter phases of `QDIV` clocks each.

Top module: `smb_master_engine`

## Requirements
- R1: While idle, `scl_oe` and `sda_oe` are 0 and `busy` is 0; a `go` pulse while idle raises `busy` on the next clock.
- R2: A transaction starts with SDA pulled low while SCL is released. SCL then stays released for at least 2*QDIV clocks before it is first pulled low. The transaction ends with SDA released while SCL is released, and SCL has been released for at least QDIV clocks before that moment.
- R3: The first byte after START is {addr[6:0], rd}, sent most-significant bit first, so the direction bit is bit 0; rd=0 means write and rd=1 means read.
- R4: Within a transaction SDA changes only while SCL is pulled low, except at the START and STOP edges.
- R5: Every SCL period inside a transaction is 4*QDIV clocks, and SCL is released for 2*QDIV clocks of each period.
- R6: In a write, the engine releases SDA during the ninth clock of each byte and samples the target's acknowledge there (low = ACK). Each data byte is taken from `wr_data` in the cycle `wr_take` pulses, and the bytes reach the target in order. `wr_take` never pulses in a read.
- R7: In a read, each byte is delivered on `rd_data` with a one-cycle `rd_valid`. The master pulls SDA low (ACK) in the ninth clock after every byte except the last, and releases it (NACK) after the last. `rd_valid` never pulses in a write.
- R8: If the address byte or any write byte is not acknowledged, the engine goes straight to STOP, sends no further byte and no further `wr_take`, and ends with `err` = 1.
- R9: A byte count of 0 sends only the address byte and then STOP, with `err` = 0 when the target acknowledges.
- R10: `done` is a one-cycle pulse in the cycle `busy` falls. `err` holds its value from the end of a transaction until the next accepted `go`, which clears it.
- R11: A `go` pulse while `busy` is 1 is ignored: no second START, and the running transaction finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| go | input | 1 | Start a transaction (honoured only when idle) |
| addr | input | 7 | Target address |
| rd | input | 1 | Direction: 1 read, 0 write |
| nbytes | input | CW | Number of data bytes |
| wr_data | input | 8 | Next byte to send |
| wr_take | output | 1 | Pulse: `wr_data` was taken |
| rd_data | output | 8 | Last byte received |
| rd_valid | output | 1 | Pulse: `rd_data` holds a new byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Pulse: transaction finished |
| err | output | 1 | Last transaction was not acknowledged |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sampled SDA line level |

## Verification
A behavioural target on the wired-AND lines is run against the engine with these cases:
- Writes of three bytes with mixed bit patterns, which tell a correct MSB-first order from reversed or shifted data.
- Reads of one and of two bytes, which separate the ACK given after a middle byte from the NACK after the last one.
- A wrong address and a NACK in the middle of a write, which show whether the engine stops at once and withholds further `wr_take` pulses.
- An address-only write, a read from an absent target, and a `go` poked mid-transfer, which cover the count-zero path, the error path in the read direction, and the rule that a busy engine ignores a new command.

Across all of these, the START and STOP edges are counted, and the SCL period and hold times are measured.

// File: rtl/smb_master_engine.sv
module smb_master_engine #(
  parameter int QDIV = 4,
  parameter int CW   = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic [6:0]    addr,
  input  logic          rd,
  input  logic [CW-1:0] nbytes,
  input  logic [7:0]    wr_data,
  output logic          wr_take,
  output logic [7:0]    rd_data,
  output logic          rd_valid,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          scl_oe,
  output logic          sda_oe,
  input  logic          sda_in
);
  localparam int QW = (QDIV > 1) ? $clog2(QDIV) : 1;

  typedef enum logic [1:0] {S_IDLE, S_START, S_BIT, S_STOP} st_t;
  st_t st;

  logic [QW-1:0] qc;
  logic [1:0]    q;
  logic [3:0]    idx;
  logic [7:0]    sh;
  logic [CW-1:0] cnt;
  logic          dir, aph, ackbad, sda_prev, cur_sda;

  wire tick    = (st != S_IDLE) && (qc == QW'(QDIV - 1));
  wire tx      = aph | ~dir;
  wire last    = (cnt == CW'(1));
  wire databit = (idx < 4'd8);
  wire lowph   = (st == S_BIT) || (st == S_STOP);

  always_comb begin
    case (st)
      S_START: cur_sda = q[1];
      S_BIT:   cur_sda = databit ? (tx & ~sh[7]) : (~tx & ~last);
      S_STOP:  cur_sda = (q != 2'd3);
      default: cur_sda = 1'b0;
    endcase
  end

  assign sda_oe = (lowph && q == 2'd0) ? sda_prev : cur_sda;
  assign scl_oe = lowph && !q[1];
  assign busy   = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; qc <= '0; q <= '0; idx <= '0; sh <= '0; cnt <= '0;
      dir <= 1'b0; aph <= 1'b0; ackbad <= 1'b0; sda_prev <= 1'b0;
      wr_take <= 1'b0; rd_valid <= 1'b0; rd_data <= '0; done <= 1'b0; err <= 1'b0;
    end else begin
      wr_take  <= 1'b0;
      rd_valid <= 1'b0;
      done     <= 1'b0;
      if (st == S_IDLE) begin
        qc <= '0;
        q  <= '0;
        if (go) begin
          st  <= S_START;
          sh  <= {addr, rd};
          dir <= rd;
          cnt <= nbytes;
          aph <= 1'b1;
          idx <= '0;
          err <= 1'b0;
        end
      end else begin
        qc <= tick ? '0 : qc + 1'b1;
        if (tick) q <= q + 2'd1;
        if (tick && q == 2'd3) sda_prev <= cur_sda;
        case (st)
          S_START: if (tick && q == 2'd3) st <= S_BIT;
          S_BIT: begin
            if (tick && q == 2'd2) begin
              if (databit && !tx) sh <= {sh[6:0], sda_in};
              if (!databit && tx) ackbad <= sda_in;
            end
            if (tick && q == 2'd3) begin
              if (databit) begin
                idx <= idx + 4'd1;
                if (tx) sh <= {sh[6:0], 1'b0};
              end else begin
                idx <= '0;
                aph <= 1'b0;
                if (tx && ackbad) begin
                  err <= 1'b1;
                  st  <= S_STOP;
                end else begin
                  if (!aph && !tx) begin
                    rd_data  <= sh;
                    rd_valid <= 1'b1;
                  end
                  if (!aph) cnt <= cnt - 1'b1;
                  if ((aph && cnt == '0) || (!aph && last)) st <= S_STOP;
                  else if (!dir) begin
                    sh      <= wr_data;
                    wr_take <= 1'b1;
                  end
                end
              end
            end
          end
          S_STOP: if (tick && q == 2'd3) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/smb_master_engine_chk.sv
module smb_master_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       go,
  input logic       busy,
  input logic       done,
  input logic       err,
  input logic       wr_take,
  input logic       rd_valid,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic [1:0] st,
  input logic       dir
);
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe)); // R1
  AST_START_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && !scl_oe) |-> (st == 2'd1)); // R2
  AST_SDA_STEADY_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && !scl_oe && $past(!scl_oe) && $past(st) == 2'd2) |-> $stable(sda_oe)); // R4
  AST_TAKE_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> (!dir && busy)); // R6
  AST_RVALID_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (dir && busy)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R10
  AST_ERR_CLEARS_ON_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (go && !busy) |=> !err); // R10
endmodule

bind smb_master_engine smb_master_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .go(go), .busy(busy), .done(done), .err(err),
  .wr_take(wr_take), .rd_valid(rd_valid), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .st(st), .dir(dir)
);

// File: tb/smb_master_engine_tb.sv
module smb_master_engine_tb_top;
  localparam int QDIV = 4;
  localparam logic [6:0] SADDR = 7'h2A;

  logic clk = 1'b0, rst_n = 1'b0, go = 1'b0, rd = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] nbytes = '0, wr_data = '0, rd_data;
  logic wr_take, rd_valid, busy, done, err, scl_oe, sda_oe, sda_in;
  logic slv_low = 1'b0;

  always #5 clk = ~clk;

  wire scl_line = ~scl_oe;
  wire sda_line = ~(sda_oe | slv_low);
  assign sda_in = sda_line;

  smb_master_engine #(.QDIV(QDIV), .CW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .go(go), .addr(addr), .rd(rd), .nbytes(nbytes),
    .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .busy(busy), .done(done), .err(err), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .sda_in(sda_in));

  int n_cmp = 0, n_bad = 0, cyc = 0;
  logic [7:0] exp_wr[$];
  logic [7:0] exp_rd[$];
  logic [7:0] rd_pat[$];
  logic       mack_log[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // target model
  logic p_scl = 1'b1, p_sda = 1'b1, active = 1'b0, armed = 1'b0, is_addr = 1'b0, in_tx = 1'b0;
  logic [7:0] srx = '0, stx = '0, addr_seen = '0;
  int bitn = 0, starts = 0, stops = 0, data_idx = 0, nack_at = -1;

  always @(negedge clk) begin
    if (scl_line && p_scl && p_sda && !sda_line) begin
      starts++; active = 1; armed = 1; bitn = 0; is_addr = 1; in_tx = 0;
      srx = 0; slv_low = 0; data_idx = 0;
    end else if (scl_line && p_scl && !p_sda && sda_line) begin
      stops++; active = 0; slv_low = 0;
    end else if (active && scl_line && !p_scl) begin
      if (bitn < 8) begin
        if (!in_tx) srx = {srx[6:0], sda_line};
      end else if (in_tx) mack_log.push_back(sda_line);
    end else if (active && !scl_line && p_scl) begin
      if (armed) armed = 0;
      else if (bitn < 7) begin
        bitn++;
        if (in_tx) slv_low = ~stx[7-bitn];
      end else if (bitn == 7) begin
        bitn = 8;
        if (is_addr) begin
          addr_seen = srx;
          slv_low = (srx[7:1] == SADDR);
        end else if (!in_tx) begin
          if (exp_wr.size() == 0) chk(0, "R6 unexpected byte at target", srx, -1);
          else begin
            automatic logic [7:0] e = exp_wr.pop_front();
            chk(srx == e, "R6 byte at target", srx, e);
          end
          slv_low = (data_idx != nack_at);
          data_idx++;
        end else slv_low = 0;
      end else begin
        bitn = 0;
        if (is_addr) begin
          is_addr = 0;
          in_tx = addr_seen[0] && (addr_seen[7:1] == SADDR);
        end else if (in_tx && mack_log.size() > 0 && mack_log[mack_log.size()-1]) in_tx = 0;
        if (in_tx) begin
          stx = (rd_pat.size() > 0) ? rd_pat.pop_front() : 8'hFF;
          slv_low = ~stx[7];
        end else slv_low = 0;
        srx = 0;
      end
    end
    p_scl = scl_line; p_sda = sda_line;
  end

  // timing monitor
  logic t_scl = 1'b1, t_sda = 1'b1;
  int t_rise = -1, t_start = -1, n_per = 0, bad_per = 0, n_high = 0, bad_high = 0;
  int n_sh = 0, bad_sh = 0, n_ph = 0, bad_ph = 0;
  always @(negedge clk) begin
    cyc++;
    if (scl_line && t_scl && t_sda && !sda_line) t_start = cyc;
    if (scl_line && t_scl && !t_sda && sda_line) begin
      n_ph++; if (t_rise < 0 || cyc - t_rise < QDIV) bad_ph++;
    end
    if (scl_line && !t_scl) begin
      if (t_rise >= 0) begin n_per++; if (cyc - t_rise != 4*QDIV) bad_per++; end
      t_rise = cyc;
    end
    if (!scl_line && t_scl) begin
      if (t_rise >= 0) begin n_high++; if (cyc - t_rise != 2*QDIV) bad_high++; end
      if (t_start >= 0) begin n_sh++; if (cyc - t_start < 2*QDIV) bad_sh++; t_start = -1; end
    end
    if (done) t_rise = -1;
    t_scl = scl_line; t_sda = sda_line;
    if (cyc == 150000) begin
      chk(0, "watchdog expired", cyc, 0);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // host side
  logic [31:0] cur_d = '0;
  int widx = 0, takes = 0, rvs = 0;
  always @(negedge clk) begin
    if (wr_take) begin
      takes++; widx++;
      wr_data = 8'(cur_d >> (8*widx));
    end
    if (rd_valid) begin
      rvs++;
      if (exp_rd.size() == 0) chk(0, "R7 unexpected rd_valid", rd_data, -1);
      else begin
        automatic logic [7:0] e = exp_rd.pop_front();
        chk(rd_data == e, "R7 received byte", rd_data, e);
      end
    end
  end

  task automatic txn(input logic [6:0] a, input logic r, input int n,
                     input logic [31:0] d, input int nk, input bit poke);
    automatic bit match = (a == SADDR);
    automatic int acc = (nk >= 0 && nk < n) ? nk + 1 : n;
    automatic bit exp_err = !match || (!r && nk >= 0 && nk < n);
    automatic int s0 = starts, p0 = stops;
    automatic bit seen = 0;
    mack_log.delete();
    takes = 0; rvs = 0; widx = 0; cur_d = d; nack_at = nk;
    if (match && !r) for (int i = 0; i < acc; i++) exp_wr.push_back(8'(d >> (8*i)));
    if (match && r) for (int i = 0; i < n; i++) begin
      rd_pat.push_back(8'(d >> (8*i)));
      exp_rd.push_back(8'(d >> (8*i)));
    end
    @(negedge clk);
    addr = a; rd = r; nbytes = 8'(n); wr_data = d[7:0]; go = 1;
    @(negedge clk);
    go = 0;
    chk(busy == 1, "R1 busy after go", busy, 1);
    chk(err == 0, "R10 err cleared by go", err, 0);
    for (int i = 0; i < 6000; i++) begin
      if (poke && i == 40) begin addr = 7'h00; rd = ~r; go = 1; end
      if (poke && i == 41) go = 0;
      @(negedge clk);
      if (done) begin seen = 1; break; end
    end
    chk(seen, "R10 done pulse", seen, 1);
    chk(busy == 0 && scl_oe == 0 && sda_oe == 0, "R1 idle after done", {busy, scl_oe, sda_oe}, 0);
    chk(err == exp_err, "R8 err flag", err, exp_err);
    chk(starts - s0 == 1 && stops - p0 == 1, "R4 one START and one STOP", (starts-s0)*10 + stops-p0, 11);
    chk(addr_seen == {a, r}, "R3 address byte", addr_seen, {a, r});
    chk(takes == ((match && !r) ? acc : 0), "R6 wr_take count", takes, (match && !r) ? acc : 0);
    chk(rvs == ((match && r) ? n : 0), "R7 rd_valid count", rvs, (match && r) ? n : 0);
    chk(exp_wr.size() == 0 && exp_rd.size() == 0, "R6 scoreboard drained", exp_wr.size() + exp_rd.size(), 0);
    if (match && r) begin
      chk(mack_log.size() == n, "R7 ack count", mack_log.size(), n);
      for (int i = 0; i < mack_log.size(); i++)
        chk(mack_log[i] == (i == n-1), "R7 master ack level", mack_log[i], i == n-1);
    end
    repeat (3) @(negedge clk);
    chk(err == exp_err, "R10 err holds after done", err, exp_err);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(scl_oe == 0 && sda_oe == 0 && busy == 0 && done == 0, "R1 reset state", {scl_oe, sda_oe, busy, done}, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(scl_oe == 0 && sda_oe == 0 && busy == 0, "R1 idle released", {scl_oe, sda_oe, busy}, 0);
    txn(SADDR, 1'b0, 3, 32'h000F3CA5, -1, 0);  // R6 plain write
    txn(SADDR, 1'b1, 2, 32'h00000196, -1, 0);  // R7 two-byte read
    txn(SADDR, 1'b1, 1, 32'h000000C3, -1, 0);  // R7 single-byte read, NACK at once
    txn(7'h11, 1'b0, 2, 32'h00005566, -1, 0);  // R8 address not acknowledged
    txn(SADDR, 1'b0, 3, 32'h00817E42, 1, 0);   // R8 NACK on second write byte
    txn(SADDR, 1'b0, 0, 32'h0, -1, 0);         // R9 address only
    txn(SADDR, 1'b0, 1, 32'h0000005A, -1, 1);  // R11 go while busy
    txn(7'h55, 1'b1, 2, 32'h0000AAAA, -1, 0);  // R8 read from absent target
    chk(n_per > 0 && bad_per == 0, "R5 SCL period", bad_per, 0);
    chk(n_high > 0 && bad_high == 0, "R5 SCL high time", bad_high, 0);
    chk(n_sh == 8 && bad_sh == 0, "R2 START hold", bad_sh, 0);
    chk(n_ph == 8 && bad_ph == 0, "R2 STOP setup", bad_ph, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule